// File: doc/BRIEF.md
# Transmit Byte Queue with Byte and Word Push Ports

This block sits between a register-mapped host port and a serial shift sequencer and holds the outgoing bytes of a transfer. The host fills it through two push ports. The single-byte port loads one byte per write. The word port loads a 32-bit value as four bytes in one cycle, starting with the least-significant byte. Both ports feed one byte-wide queue. The sequencer drains that queue one byte per pop.

The host paces its writes from a status word whose upper half gives the number of free byte slots. Three level flags are provided: empty, full and a sticky overrun. A push that does not fit is discarded completely and raises the overrun flag. A word push never lands partly. The storage is split into four byte lanes, each a simple dual-port memory. This lets a word push write every lane in one cycle, and a block RAM can still be inferred for each lane.

Top module: `txq_byte_fifo`

## Requirements
- R1: After a synchronous reset, the free count equals DEPTH, empty is 1, full is 0 and overrun is 0.
- R2: A byte-port push (`push_byte`) stores bits 7:0 of `push_data` as one entry and lowers the free count by 1 at the next clock edge.
- R3: A word-port push (`push_word`) stores four entries, bits 7:0 first and bits 31:24 last, and lowers the free count by 4 at the next clock edge.
- R4: A pop accepted at a clock edge presents the oldest stored byte on `pop_data` with `pop_valid` high right after that edge. The order of entries is kept across mixed byte and word pushes and across address wrap-around.
- R5: `xfer_status[31:16]` holds the free count as an unsigned number, and `xfer_status[15:0]` reads as zero.
- R6: A word push that arrives while fewer than 4 slots are free is discarded with none of its bytes stored, and it sets the overrun flag.
- R7: A byte push that arrives while no slot is free is discarded and sets the overrun flag.
- R8: Overrun stays set until a cycle with `ovr_clear` high and no new overrun. If a new overrun and a clear occur in the same cycle, the flag stays set.
- R9: `empty` is high exactly when the queue holds no entries, and it rises right after the edge that pops the last byte. `full` is high exactly when the free count is 0.
- R10: A pop while empty is ignored: `pop_valid` stays low and the free count does not change.
- R11: If both push ports are asserted in one cycle, only the word push is considered. The byte push is ignored and cannot raise overrun.
- R12: A push and a pop may complete in the same cycle. Room for the push is judged on the free count before that pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_byte | input | 1 | Push the low byte of push_data |
| push_word | input | 1 | Push all four bytes of push_data |
| push_data | input | 32 | Write data from the host port |
| pop | input | 1 | Sequencer request for the next byte |
| ovr_clear | input | 1 | Clears the sticky overrun flag |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | pop_data holds a byte popped at the previous edge |
| xfer_status | output | 32 | Free byte count in bits 31:16, zero below |
| empty | output | 1 | Queue holds no bytes |
| full | output | 1 | No free slot |
| overrun | output | 1 | Sticky dropped-push flag |

## Verification
The bench builds the block with DEPTH set to 16, so that four words fill it. With that setting the full flag, both overrun paths and the word push refused with 1 to 3 slots free all come up within a few dozen cycles. Read and write pointers wrap many times during the random phase, so lane steering and pointer wrap-around are exercised at every lane offset. The bench also uses a word-push sequence to check alignment against a byte-aligned write pointer.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;

  // Which byte of a pushed word lands in lane b when the write pointer sits at lane wl.
  function automatic logic [1:0] lane_offset(input logic [1:0] b, input logic [1:0] wl);
    return b - wl;
  endfunction
endpackage

// File: rtl/txq_lane.sv
module txq_lane #(
  parameter int ROWS = 16,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [RW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_byte,
  input  logic          push_word,
  input  logic          pop,
  input  logic          ovr_clear,
  output logic          byte_ok,
  output logic          word_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic [CW-1:0] free_q,
  output logic          empty_q,
  output logic          full_q,
  output logic          ovr_q
);
  logic [2:0]    add;
  logic          ovr_set;
  logic [CW-1:0] free_n;

  always_comb begin
    word_ok = push_word && (free_q >= CW'(4));
    byte_ok = push_byte && !push_word && (free_q != '0);
    ovr_set = (push_word && (free_q < CW'(4))) ||
              (push_byte && !push_word && (free_q == '0));
    pop_ok  = pop && !empty_q;
    add     = word_ok ? 3'd4 : (byte_ok ? 3'd1 : 3'd0);
    free_n  = free_q - CW'(add) + CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      free_q  <= CW'(DEPTH);
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      wp      <= wp + AW'(add);
      rp      <= rp + AW'(pop_ok);
      free_q  <= free_n;
      empty_q <= (free_n == CW'(DEPTH));
      full_q  <= (free_n == '0);
      ovr_q   <= ovr_set | (ovr_q & ~ovr_clear);
    end
  end

  // R6: a word push that does not fit leaves the count alone and flags overrun
  assert_drop_word_R6: assert property (@(posedge clk) disable iff (rst)
    (push_word && (free_q < CW'(4)) && !pop) |=> ($stable(free_q) && ovr_q));
  // R7: a byte push with no room flags overrun and stores nothing
  assert_drop_byte_R7: assert property (@(posedge clk) disable iff (rst)
    (push_byte && !push_word && (free_q == '0) && !pop) |=> (ovr_q && (free_q == '0)));
  // R8: overrun holds until cleared
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !ovr_clear) |=> ovr_q);
  // R9: flag levels agree with the free count
  assert_empty_level_R9: assert property (@(posedge clk) disable iff (rst)
    empty_q |-> (free_q == CW'(DEPTH)));
  assert_full_level_R9: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (free_q == '0));
  // R5: free count never exceeds the depth
  assert_free_bound_R5: assert property (@(posedge clk) disable iff (rst)
    free_q <= CW'(DEPTH));
endmodule

// File: rtl/txq_byte_fifo.sv
module txq_byte_fifo #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push_byte,
  input  logic        push_word,
  input  logic [31:0] push_data,
  input  logic        pop,
  input  logic        ovr_clear,
  output logic [7:0]  pop_data,
  output logic        pop_valid,
  output logic [31:0] xfer_status,
  output logic        empty,
  output logic        full,
  output logic        overrun
);
  import txq_pkg::*;

  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int ROWS = DEPTH / LANES;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic          byte_ok, word_ok, pop_ok;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] free_q;
  logic [1:0]    sel_q;
  logic [7:0]    lane_q [LANES];

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_byte(push_byte), .push_word(push_word),
    .pop(pop), .ovr_clear(ovr_clear),
    .byte_ok(byte_ok), .word_ok(word_ok), .pop_ok(pop_ok),
    .wp(wp), .rp(rp), .free_q(free_q),
    .empty_q(empty), .full_q(full), .ovr_q(overrun)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [1:0]    off;
    logic [AW-1:0] slot;
    logic          we_l;
    logic [7:0]    wd_l;

    always_comb begin
      off  = lane_offset(2'(b), wp[1:0]);
      slot = wp + AW'(off);
      we_l = word_ok || (byte_ok && (wp[1:0] == 2'(b)));
      wd_l = word_ok ? push_data[8*off +: 8] : push_data[7:0];
    end

    txq_lane #(.ROWS(ROWS)) u_lane (
      .clk(clk),
      .we(we_l), .waddr(RW'(slot >> 2)), .wdata(wd_l),
      .re(pop_ok && (rp[1:0] == 2'(b))), .raddr(RW'(rp >> 2)),
      .rdata(lane_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      sel_q     <= '0;
    end else begin
      pop_valid <= pop_ok;
      if (pop_ok) sel_q <= rp[1:0];
    end
  end

  assign pop_data    = lane_q[sel_q];
  assign xfer_status = {16'(free_q), 16'h0000};

  // R10: popping an empty queue yields nothing
  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> !pop_valid);
  // R2: an accepted lone byte push takes exactly one slot when no pop occurs
  assert_byte_take_R2: assert property (@(posedge clk) disable iff (rst)
    (push_byte && !push_word && !full && !pop) |=> (xfer_status[31:16] == $past(xfer_status[31:16]) - 16'd1));
  // R11: with both ports asserted the count moves by a word or not at all
  assert_word_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (push_byte && push_word && !pop) |=> ((xfer_status[31:16] == $past(xfer_status[31:16]) - 16'd4) ||
                                          (xfer_status[31:16] == $past(xfer_status[31:16]))));
endmodule

// File: tb/tb_txq_byte_fifo.sv
module tb_txq_byte_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_byte = 1'b0, push_word = 1'b0, pop = 1'b0, ovr_clear = 1'b0;
  logic [31:0] push_data = '0;
  logic [7:0]  pop_data;
  logic        pop_valid, empty, full, overrun;
  logic [31:0] xfer_status;

  int errors = 0;
  int checks = 0;
  logic [7:0] model[$];
  bit ovr_m = 1'b0;

  always #5 clk = ~clk;

  txq_byte_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .push_byte(push_byte), .push_word(push_word),
    .push_data(push_data), .pop(pop), .ovr_clear(ovr_clear),
    .pop_data(pop_data), .pop_valid(pop_valid), .xfer_status(xfer_status),
    .empty(empty), .full(full), .overrun(overrun)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {16'(DEPTH - model.size()), 16'h0000};
  endfunction

  task automatic check_all(input string tag, input bit ev, input logic [7:0] eb);
    chk(tag, "pop_valid", pop_valid, ev);
    if (ev) chk(tag, "pop_data", pop_data, eb);
    chk(tag, "xfer_status", xfer_status, exp_status());
    chk(tag, "empty", empty, model.size() == 0);
    chk(tag, "full", full, model.size() == DEPTH);
    chk(tag, "overrun", overrun, ovr_m);
  endtask

  task automatic step(input string tag, input bit be, input bit we, input logic [31:0] d,
                      input bit p, input bit c);
    int fr;
    bit set, ev;
    logic [7:0] eb;
    @(negedge clk);
    push_byte = be; push_word = we; push_data = d; pop = p; ovr_clear = c;
    fr = DEPTH - model.size();
    ev = p && (model.size() > 0);
    eb = 8'h00;
    if (ev) eb = model.pop_front();
    set = 1'b0;
    if (we) begin
      if (fr >= 4) for (int k = 0; k < 4; k++) model.push_back(d[8*k +: 8]);
      else set = 1'b1;
    end else if (be) begin
      if (fr >= 1) model.push_back(d[7:0]);
      else set = 1'b1;
    end
    ovr_m = set ? 1'b1 : (c ? 1'b0 : ovr_m);
    @(posedge clk);
    #1;
    check_all(tag, ev, eb);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_all("R1", 1'b0, 8'h00);                       // R1 reset state
    step("R2", 1, 0, 32'h0000_00A5, 0, 0);              // R2 lone byte
    step("R4", 0, 0, 32'h0, 1, 0);                      // R4 pop it back, R9 empty rises
    step("R10", 0, 0, 32'h0, 1, 0);                     // R10 pop while empty
    step("R3", 0, 1, 32'h4433_2211, 0, 0);              // R3 word, LSB first
    for (int i = 0; i < 4; i++) step("R4", 0, 0, 32'h0, 1, 0);
    step("R2", 1, 0, 32'h0000_0077, 0, 0);              // misalign the write pointer
    for (int i = 0; i < 3; i++) step("R3", 0, 1, 32'hD0C0B0A0 + 32'(i), 0, 0);
    step("R6", 0, 1, 32'hDEAD_BEEF, 0, 0);              // R6 free=3, word dropped
    step("R8", 0, 0, 32'h0, 0, 0);                      // R8 overrun holds
    step("R8", 0, 0, 32'h0, 0, 1);                      // R8 clear
    for (int i = 0; i < 3; i++) step("R2", 1, 0, 32'h0000_0060 + 32'(i), 0, 0);
    step("R7", 1, 0, 32'h0000_00EE, 0, 0);              // R7 full, byte dropped; R9 full
    step("R8", 1, 0, 32'h0000_00EF, 0, 1);              // R8 set beats clear
    step("R12", 0, 1, 32'h1234_5678, 1, 0);             // R12 pop frees 1 but word judged on 0
    step("R12", 1, 0, 32'h0000_0033, 1, 1);             // R12 byte judged on free=1 before pop
    for (int i = 0; i < DEPTH; i++) step("R4", 0, 0, 32'h0, 1, 0);  // drain, R9 empty
    step("R11", 1, 1, 32'hCAFE_F00D, 0, 0);             // R11 word wins
    for (int i = 0; i < 4; i++) step("R11", 0, 0, 32'h0, 1, 0);
    for (int i = 0; i < 3000; i++) begin                // R4 R5 R12 random mix with wrap
      bit fillp;
      fillp = ((i / 150) % 2) == 0;
      step("R4", ($urandom % 3) == 0, ($urandom % (fillp ? 3 : 6)) == 0, $urandom,
           ($urandom % (fillp ? 4 : 2)) == 0, ($urandom % 16) == 0);
    end
    finish_run();
  end
endmodule